// File: doc/BRIEF.md
# Partition ID label generator

This block computes the instruction-side and data-side partition IDs that are attached to outgoing memory requests. Two register pairs feed it. The lower pair belongs to the application level (EL0) and the upper pair belongs to the kernel level (EL1). The block takes the current level, the hypervisor state bits and three hypervisor control bits. From these it first decides which pair is the source. It then decides whether the chosen IDs are virtual. When they are virtual, each ID is looked up in a table of eight hypervisor-owned mapping registers.

The instruction ID and the data ID are translated on separate paths. A mapped virtual ID that falls outside the table sets an out-of-range flag and forces that side's label to zero. The result is registered. A label therefore appears on the clock edge that follows the inputs it was computed from. Programming the registers and raising exceptions are handled elsewhere.

Top module: `pidlbl_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, both label outputs and `pid_oor` become 0 after that edge.
- R2: The outputs change only at a rising edge, and they reflect the inputs sampled at that edge (one cycle of latency).
- R3: When `at_el1` is 1, the upper pair (`hi_pid_i`, `hi_pid_d`) is the source, and `map_en_lo` has no effect.
- R4: When `at_el1` is 0, `el2_en` is 1, `hyp_tge` is 0 and `app_lock` is 1, the upper pair is the source. In that case `map_en_hi` alone decides whether mapping applies, and `map_en_lo` has no effect.
- R5: At EL0 in every other case, the lower pair is the source, and `map_en_lo` decides whether mapping applies.
- R6: When `hyp_e2h` and `hyp_tge` are both 1, `map_en_lo` is ignored and the lower-pair IDs pass through unmapped.
- R7: When `el2_en` is 0, the mapping enables and `app_lock` have no effect. EL0 takes the lower pair raw and EL1 takes the upper pair raw, and `pid_oor` stays 0.
- R8: When mapping applies, a virtual ID v below 32 is replaced by a table entry. Register r = v[4:2] sits at `map_regs` bits [64r+63:64r]. Field f = v[1:0] sits at bits [16f+15:16f] of that register.
- R9: The instruction ID and the data ID are translated independently. Each one selects its own table entry.
- R10: When mapping applies and a virtual ID is 32 or more, that side's label is 0 and `pid_oor` is 1. The other side is still translated normally. An unmapped ID passes through unchanged whatever its value, and it never raises `pid_oor`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| at_el1 | input | 1 | Current level: 0 = EL0, 1 = EL1 |
| el2_en | input | 1 | Hypervisor level enabled in this security state |
| hyp_tge | input | 1 | Hypervisor trap-general-exceptions bit |
| hyp_e2h | input | 1 | Hypervisor host-extension bit |
| map_en_lo | input | 1 | Mapping enable for lower-pair IDs |
| map_en_hi | input | 1 | Mapping enable for upper-pair IDs |
| app_lock | input | 1 | Make EL0 use the upper pair |
| lo_pid_i | input | 16 | EL0 instruction partition ID |
| lo_pid_d | input | 16 | EL0 data partition ID |
| hi_pid_i | input | 16 | EL1 instruction partition ID |
| hi_pid_d | input | 16 | EL1 data partition ID |
| map_regs | input | 512 | Eight 64-bit mapping registers, each holding four 16-bit fields |
| phys_pid_i | output | 16 | Physical instruction partition ID |
| phys_pid_d | output | 16 | Physical data partition ID |
| pid_oor | output | 1 | A mapped virtual ID was out of range |

## Verification
The only internal state is the output register, so any fault shows up in the label one edge after the inputs that exposed it. A wrong source choice returns the other pair's value. A wrong mapping decision returns either the raw ID or a table entry, and each table entry is distinct so that the two cases can be told apart. A wrong table index returns a neighbouring entry. The tests cover every condition in the source decision and the boundary IDs 0, 31, 32 and 33, so any of these faults is seen on the first edge at which the condition occurs.

// File: rtl/pidlbl_pkg.sv
// Package: shared widths and types for the partition ID label generator.
// Assumes a 16-bit partition ID and 64-bit mapping registers.
package pidlbl_pkg;
    localparam int PID_W_DEF    = 16;
    localparam int MAP_REGS_DEF = 8;
    localparam int FIELDS_DEF   = 4;

    // Which register pair supplies the labels
    typedef enum logic {
        SRC_LO = 1'b0,
        SRC_HI = 1'b1
    } pid_src_e;

    // Routing decision shared by both sides
    typedef struct packed {
        pid_src_e src;
        logic     map_en;
    } route_t;
endpackage

// File: rtl/pidlbl_route.sv
// Module: pidlbl_route
// Chooses the source register pair and decides whether mapping applies.
// Assumes that every control bit is ignored when el2_en is low.
module pidlbl_route
    import pidlbl_pkg::*;
(
    input  logic   at_el1,
    input  logic   el2_en,
    input  logic   hyp_tge,
    input  logic   hyp_e2h,
    input  logic   map_en_lo,
    input  logic   map_en_hi,
    input  logic   app_lock,
    output route_t route
);
    logic lock_hi;
    logic lo_host;

    // EL0 is redirected to the upper pair only by the lock, for a guest application
    always_comb lock_hi = el2_en && !hyp_tge && app_lock;

    // Host mode at EL0 disables mapping of the lower pair
    always_comb lo_host = hyp_e2h && hyp_tge;

    // Combine into a single routing decision
    always_comb begin
        route.src    = (at_el1 || lock_hi) ? SRC_HI : SRC_LO;
        route.map_en = 1'b0;
        if (el2_en) begin
            if (route.src == SRC_HI) route.map_en = map_en_hi;
            else                     route.map_en = map_en_lo && !lo_host;
        end
    end
endmodule

// File: rtl/pidlbl_xlate.sv
// Module: pidlbl_xlate
// Translates one virtual partition ID through the flattened mapping table.
// Assumes that entry g sits at bits [g*PID_W +: PID_W] of map_regs.
module pidlbl_xlate #(
    parameter int PID_W    = 16,
    parameter int MAP_REGS = 8,
    parameter int FIELDS   = 4
) (
    input  logic [PID_W-1:0]                 vid,
    input  logic                             map_en,
    input  logic [MAP_REGS*FIELDS*PID_W-1:0] map_regs,
    output logic [PID_W-1:0]                 pid,
    output logic                             oor
);
    localparam int ENTRIES = MAP_REGS * FIELDS;
    localparam int IDX_W   = $clog2(ENTRIES);

    logic [PID_W-1:0] tbl [ENTRIES];
    logic             in_range;

    // Unpack the flat register image into table entries
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        assign tbl[g] = map_regs[g*PID_W +: PID_W];
    end

    // The upper bits of the ID must be zero for a valid index
    always_comb in_range = ((vid >> IDX_W) == '0);

    // Pass the ID through, look it up, or flag it as out of range
    always_comb begin
        pid = vid;
        oor = 1'b0;
        if (map_en) begin
            if (in_range) begin
                pid = tbl[vid[IDX_W-1:0]];
            end else begin
                pid = '0;
                oor = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pidlbl_gen.sv
// Module: pidlbl_gen (top)
// Produces registered physical instruction and data partition IDs.
// Assumes synchronous active-low reset and one cycle of latency.
module pidlbl_gen
    import pidlbl_pkg::*;
#(
    parameter int PID_W    = PID_W_DEF,
    parameter int MAP_REGS = MAP_REGS_DEF,
    parameter int FIELDS   = FIELDS_DEF
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             at_el1,
    input  logic                             el2_en,
    input  logic                             hyp_tge,
    input  logic                             hyp_e2h,
    input  logic                             map_en_lo,
    input  logic                             map_en_hi,
    input  logic                             app_lock,
    input  logic [PID_W-1:0]                 lo_pid_i,
    input  logic [PID_W-1:0]                 lo_pid_d,
    input  logic [PID_W-1:0]                 hi_pid_i,
    input  logic [PID_W-1:0]                 hi_pid_d,
    input  logic [MAP_REGS*FIELDS*PID_W-1:0] map_regs,
    output logic [PID_W-1:0]                 phys_pid_i,
    output logic [PID_W-1:0]                 phys_pid_d,
    output logic                             pid_oor
);
    localparam int SIDES = 2;

    route_t           route;
    logic [PID_W-1:0] vid  [SIDES];
    logic [PID_W-1:0] ppid [SIDES];
    logic             oor  [SIDES];

    pidlbl_route u_route (
        .at_el1    (at_el1),
        .el2_en    (el2_en),
        .hyp_tge   (hyp_tge),
        .hyp_e2h   (hyp_e2h),
        .map_en_lo (map_en_lo),
        .map_en_hi (map_en_hi),
        .app_lock  (app_lock),
        .route     (route)
    );

    // Select the virtual IDs from the chosen pair (side 0 = instruction, side 1 = data)
    always_comb begin
        vid[0] = (route.src == SRC_HI) ? hi_pid_i : lo_pid_i;
        vid[1] = (route.src == SRC_HI) ? hi_pid_d : lo_pid_d;
    end

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        pidlbl_xlate #(
            .PID_W    (PID_W),
            .MAP_REGS (MAP_REGS),
            .FIELDS   (FIELDS)
        ) u_xlate (
            .vid      (vid[s]),
            .map_en   (route.map_en),
            .map_regs (map_regs),
            .pid      (ppid[s]),
            .oor      (oor[s])
        );
    end

    // Register the labels and the range flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_pid_i <= '0;
            phys_pid_d <= '0;
            pid_oor    <= 1'b0;
        end else begin
            phys_pid_i <= ppid[0];
            phys_pid_d <= ppid[1];
            pid_oor    <= oor[0] || oor[1];
        end
    end
endmodule

// File: rtl/pidlbl_chk.sv
// Module: pidlbl_chk
// Checks timing properties on the ports of pidlbl_gen.
// Attached to the top module with a bind statement.
module pidlbl_chk #(
    parameter int PID_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             at_el1,
    input logic             el2_en,
    input logic             hyp_tge,
    input logic             hyp_e2h,
    input logic             map_en_hi,
    input logic             app_lock,
    input logic [PID_W-1:0] lo_pid_i,
    input logic [PID_W-1:0] lo_pid_d,
    input logic [PID_W-1:0] hi_pid_i,
    input logic [PID_W-1:0] hi_pid_d,
    input logic [PID_W-1:0] phys_pid_i,
    input logic [PID_W-1:0] phys_pid_d,
    input logic             pid_oor
);
    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (phys_pid_i == '0 && phys_pid_d == '0 && !pid_oor)); // R1

    AST_EL1_RAW_NO_EL2: assert property (@(posedge clk) disable iff (!rst_n)
        (at_el1 && !el2_en) |=> (phys_pid_i == $past(hi_pid_i) && phys_pid_d == $past(hi_pid_d) && !pid_oor)); // R7

    AST_EL0_RAW_NO_EL2: assert property (@(posedge clk) disable iff (!rst_n)
        (!at_el1 && !el2_en) |=> (phys_pid_i == $past(lo_pid_i) && phys_pid_d == $past(lo_pid_d) && !pid_oor)); // R7

    AST_HOST_NO_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!at_el1 && el2_en && hyp_tge && hyp_e2h) |=> (phys_pid_i == $past(lo_pid_i) && phys_pid_d == $past(lo_pid_d))); // R6

    AST_LOCK_HI_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (!at_el1 && el2_en && !hyp_tge && app_lock && !map_en_hi) |=> (phys_pid_i == $past(hi_pid_i) && phys_pid_d == $past(hi_pid_d))); // R4

    AST_OOR_ZERO_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        pid_oor |-> (phys_pid_i == '0 || phys_pid_d == '0)); // R10
endmodule

bind pidlbl_gen pidlbl_chk #(.PID_W(PID_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .at_el1     (at_el1),
    .el2_en     (el2_en),
    .hyp_tge    (hyp_tge),
    .hyp_e2h    (hyp_e2h),
    .map_en_hi  (map_en_hi),
    .app_lock   (app_lock),
    .lo_pid_i   (lo_pid_i),
    .lo_pid_d   (lo_pid_d),
    .hi_pid_i   (hi_pid_i),
    .hi_pid_d   (hi_pid_d),
    .phys_pid_i (phys_pid_i),
    .phys_pid_d (phys_pid_d),
    .pid_oor    (pid_oor)
);

// File: tb/tb_pidlbl_gen.sv
// Directed bench for pidlbl_gen: one task per scenario, each task checks its own results.
module tb_pidlbl_gen;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         at_el1 = 1'b0, el2_en = 1'b1, hyp_tge = 1'b0, hyp_e2h = 1'b0;
    logic         map_en_lo = 1'b0, map_en_hi = 1'b0, app_lock = 1'b0;
    logic [15:0]  lo_pid_i = '0, lo_pid_d = '0, hi_pid_i = '0, hi_pid_d = '0;
    logic [511:0] map_regs;
    logic [15:0]  phys_pid_i, phys_pid_d;
    logic         pid_oor;
    int           n_chk = 0;
    int           n_err = 0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    pidlbl_gen dut (
        .clk(clk), .rst_n(rst_n), .at_el1(at_el1), .el2_en(el2_en),
        .hyp_tge(hyp_tge), .hyp_e2h(hyp_e2h), .map_en_lo(map_en_lo),
        .map_en_hi(map_en_hi), .app_lock(app_lock),
        .lo_pid_i(lo_pid_i), .lo_pid_d(lo_pid_d), .hi_pid_i(hi_pid_i), .hi_pid_d(hi_pid_d),
        .map_regs(map_regs), .phys_pid_i(phys_pid_i), .phys_pid_d(phys_pid_d), .pid_oor(pid_oor)
    );

    // Table entry value for virtual ID k (every entry distinct, none zero)
    function automatic logic [15:0] ent(int k);
        return 16'(16'h4000 + k * 16'h0111);
    endfunction

    task automatic chk(string req, logic [15:0] ei, logic [15:0] ed, logic eo);
        n_chk++;
        if (phys_pid_i !== ei || phys_pid_d !== ed || pid_oor !== eo) begin
            n_err++;
            $display("FAIL %s: got i=%h d=%h oor=%b, expected i=%h d=%h oor=%b",
                     req, phys_pid_i, phys_pid_d, pid_oor, ei, ed, eo);
        end
    endtask

    // Set the controls at the falling edge, then sample one time unit after the next rising edge
    task automatic apply(logic el1, logic e2, logic tge, logic e2h, logic mlo, logic mhi, logic lk,
                         logic [15:0] li, logic [15:0] ld, logic [15:0] hi, logic [15:0] hd);
        @(negedge clk);
        at_el1 = el1; el2_en = e2; hyp_tge = tge; hyp_e2h = e2h;
        map_en_lo = mlo; map_en_hi = mhi; app_lock = lk;
        lo_pid_i = li; lo_pid_d = ld; hi_pid_i = hi; hi_pid_d = hd;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        apply(0, 1, 0, 0, 1, 1, 0, 16'd3, 16'd4, 16'd5, 16'd6);
        chk("R1 reset", 16'h0, 16'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_latency;
        apply(0, 1, 0, 0, 0, 0, 0, 16'h0077, 16'h0088, 16'h0, 16'h0);
        @(negedge clk);
        lo_pid_i = 16'h0055; lo_pid_d = 16'h0066;
        #1;
        chk("R2 held before edge", 16'h0077, 16'h0088, 1'b0);
        @(posedge clk);
        #1;
        chk("R2 after edge", 16'h0055, 16'h0066, 1'b0);
    endtask

    task automatic t_el1;
        apply(1, 1, 0, 0, 1, 0, 0, 16'd1, 16'd2, 16'h0021, 16'h0022);
        chk("R3 upper pair, lo enable ignored", 16'h0021, 16'h0022, 1'b0);
    endtask

    task automatic t_map_index;
        apply(1, 1, 0, 0, 0, 1, 0, 16'd0, 16'd0, 16'd7, 16'd30);
        chk("R8 entries 7/30", ent(7), ent(30), 1'b0);
        apply(1, 1, 0, 0, 0, 1, 0, 16'd0, 16'd0, 16'd0, 16'd31);
        chk("R8 entries 0/31", ent(0), ent(31), 1'b0);
    endtask

    task automatic t_lock;
        apply(0, 1, 0, 0, 0, 1, 1, 16'd1, 16'd2, 16'd3, 16'd12);
        chk("R4 lock mapped by hi enable", ent(3), ent(12), 1'b0);
        apply(0, 1, 0, 0, 1, 0, 1, 16'd1, 16'd2, 16'd3, 16'd12);
        chk("R4 lock raw, lo enable ignored", 16'd3, 16'd12, 1'b0);
    endtask

    task automatic t_el0;
        apply(0, 1, 0, 0, 1, 0, 0, 16'd9, 16'd17, 16'd1, 16'd1);
        chk("R5 lo pair mapped", ent(9), ent(17), 1'b0);
        apply(0, 1, 0, 0, 0, 1, 0, 16'd9, 16'd17, 16'd1, 16'd1);
        chk("R5 lo pair raw", 16'd9, 16'd17, 1'b0);
        apply(0, 1, 1, 0, 1, 1, 1, 16'd10, 16'd11, 16'd1, 16'd1);
        chk("R5 lock with tge uses lo pair", ent(10), ent(11), 1'b0);
    endtask

    task automatic t_host;
        apply(0, 1, 1, 1, 1, 1, 1, 16'd4, 16'd5, 16'd1, 16'd1);
        chk("R6 host mode unmapped", 16'd4, 16'd5, 1'b0);
        apply(0, 1, 0, 1, 1, 0, 0, 16'd4, 16'd5, 16'd1, 16'd1);
        chk("R6 e2h alone still maps", ent(4), ent(5), 1'b0);
    endtask

    task automatic t_no_el2;
        apply(0, 0, 0, 0, 1, 1, 1, 16'd6, 16'd8, 16'd1, 16'd1);
        chk("R7 EL0 raw lo", 16'd6, 16'd8, 1'b0);
        apply(1, 0, 0, 0, 1, 1, 0, 16'd1, 16'd1, 16'd40, 16'd2);
        chk("R7 EL1 raw hi", 16'd40, 16'd2, 1'b0);
    endtask

    task automatic t_indep;
        apply(0, 1, 0, 0, 1, 0, 0, 16'd13, 16'd26, 16'd0, 16'd0);
        chk("R9 sides independent", ent(13), ent(26), 1'b0);
    endtask

    task automatic t_oor;
        apply(0, 1, 0, 0, 1, 0, 0, 16'd33, 16'd2, 16'd0, 16'd0);
        chk("R10 instr out of range", 16'h0, ent(2), 1'b1);
        apply(0, 1, 0, 0, 1, 0, 0, 16'd5, 16'd32, 16'd0, 16'd0);
        chk("R10 data boundary 32", ent(5), 16'h0, 1'b1);
        apply(0, 1, 0, 0, 0, 0, 0, 16'd200, 16'd32, 16'd0, 16'd0);
        chk("R10 unmapped large passes", 16'd200, 16'd32, 1'b0);
    endtask

    initial begin
        for (int k = 0; k < 32; k++) map_regs[(k/4)*64 + (k%4)*16 +: 16] = ent(k);
        t_reset();
        t_latency();
        t_el1();
        t_map_index();
        t_lock();
        t_el0();
        t_host();
        t_no_el2();
        t_indep();
        t_oor();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    // Watchdog: an expired run counts as one failed check
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule